// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers up to 128 peripheral interrupt lines and presents one active-low request to a processor. Software reaches every per-source setting through one indirection. It first writes a source index into a select register. The mode and vector registers then apply to that source, and so do the one-shot commands that enable it, disable it, clear its pending flag or set its pending flag. A set command is how software retriggers a source.

Each source carries a 3-bit priority and a trigger type. Level sources are pending while their input is active. Edge sources latch the event until software clears it or the processor acknowledges it. Among the enabled pending sources, the highest priority wins, and the lowest index breaks a tie. The arbitration result is registered once before it drives the request pin.

Reading the vector register acknowledges the winner. That read pushes the winner's priority and index onto a nesting stack, and after it only a strictly higher priority can raise the request again. An end-of-interrupt write pops one level. When no request qualifies, the vector read returns a programmable spurious value and changes nothing.

Top module: `irq_nest_ctrl`

## Requirements
- R1: The select register at 0x00 holds a source index in bits [6:0]. The mode register at 0x04 and the vector register at 0x08 read and write the selected source. The mode register keeps priority in bits [2:0] (7 is highest) and trigger in bits [6:5], and all its other bits read zero. The vector register is 32 bits wide.
- R2: A write of any value to 0x40 enables the selected source, and a write to 0x44 disables it. Bit 0 of 0x30 reads the selected source's enable. A disabled source never causes a request, even when it is pending.
- R3: A write to 0x4C sets the selected source's pending latch, and a write to 0x48 clears it. Source i appears at bit i mod 32 of the pending word at 0x20 + 4*(i div 32), for words 0x20, 0x24, 0x28 and 0x2C.
- R4: The trigger field selects one of four behaviours: 00 is level-high, 01 is level-low, 10 is rising edge and 11 is falling edge. A level source reads pending exactly while its input is at the active level. An edge source latches on the selected transition only and stays pending after the input returns.
- R5: irq_n goes low when some enabled pending source has a priority strictly above the top of the stack, or when the stack is empty. Among such sources the highest priority wins and ties go to the lowest index. A read of 0x10 returns the winner's vector. irq_n follows its inputs through one register stage.
- R6: When no request qualifies, a read of 0x10 returns the value last written to the spurious register at 0x3C. Such a read leaves the stack unchanged.
- R7: A read of 0x10 while a request qualifies pushes the winner's priority and index and clears the winner's pending latch. After that, a source of equal or lower priority does not assert irq_n.
- R8: The status register at 0x18 reads the index on top of the stack, and reads zero when the stack is empty.
- R9: A write to 0x38 pops one nesting level. The stack holds up to 8 levels. Eight such writes in a row always return the block to the empty, idle state, and a write while the stack is empty has no effect.
- R10: After reset, irq_n is high. All enables, pending latches, modes, vectors, the spurious value and the stack are zero.
- R11: When the select register holds an index at or above the number of implemented sources, mode writes, vector writes and commands are ignored. Mode, vector and enable reads return zero, and no pending bit appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per access |
| bus_rd | input | 1 | Register read strobe, one cycle per access |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| src_in | input | NUM_SRC | Peripheral interrupt lines, synchronous to clk |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The bench goes after the case where two sources share the top priority. A wrong tie-break there would return the higher index's vector. It also checks that a source of equal priority stays masked while a level is in service. A comparison that is not strict would re-raise irq_n and nest a source into its own level. The bench fills the stack with eight rising priorities and then drains it with eight end-of-interrupt writes. An off-by-one in the stack counter would leave a non-zero status or lose the bottom level. Edge sources are driven with the opposite transition to show that they do not latch, and an out-of-range select is shown to have no effect on any readable state.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  localparam int MAX_SRC = 128;
  localparam int SEL_W   = 7;
  localparam int PRIO_W  = 3;
  localparam int DATA_W  = 32;

  localparam logic [7:0] A_SEL   = 8'h00;
  localparam logic [7:0] A_MODE  = 8'h04;
  localparam logic [7:0] A_VEC   = 8'h08;
  localparam logic [7:0] A_IVR   = 8'h10;
  localparam logic [7:0] A_STAT  = 8'h18;
  localparam logic [7:0] A_PEND0 = 8'h20;
  localparam logic [7:0] A_PEND1 = 8'h24;
  localparam logic [7:0] A_PEND2 = 8'h28;
  localparam logic [7:0] A_PEND3 = 8'h2C;
  localparam logic [7:0] A_MASK  = 8'h30;
  localparam logic [7:0] A_EOI   = 8'h38;
  localparam logic [7:0] A_SPU   = 8'h3C;
  localparam logic [7:0] A_EN    = 8'h40;
  localparam logic [7:0] A_DIS   = 8'h44;
  localparam logic [7:0] A_CLR   = 8'h48;
  localparam logic [7:0] A_SET   = 8'h4C;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  typedef struct packed {
    trig_e             trig;
    logic [PRIO_W-1:0] prio;
  } mode_t;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;
    logic [SEL_W-1:0]  idx;
  } level_t;

  function automatic logic [DATA_W-1:0] mode_word(mode_t m);
    return {25'b0, m.trig, 2'b00, m.prio};
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_nest_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_in,
  input  logic              hit,
  input  logic              wr_mode,
  input  logic              wr_vec,
  input  logic              do_en,
  input  logic              do_dis,
  input  logic              do_clr,
  input  logic              do_set,
  input  logic              ack,
  input  logic [DATA_W-1:0] wdata,
  output logic              pend,
  output logic              en,
  output mode_t             mode,
  output logic [DATA_W-1:0] vec
);

  logic              en_q, en_d, en_ld;
  logic              lat_q, lat_d;
  logic              prev_q;
  mode_t             mode_q, mode_d;
  logic              mode_ld, vec_ld;
  logic [DATA_W-1:0] vec_q;
  logic              lvl_act, edge_act;

  // trigger decode
  always_comb begin
    lvl_act  = 1'b0;
    edge_act = 1'b0;
    case (mode_q.trig)
      TRIG_HIGH: lvl_act  = src_in;
      TRIG_LOW:  lvl_act  = ~src_in;
      TRIG_RISE: edge_act = src_in & ~prev_q;
      TRIG_FALL: edge_act = ~src_in & prev_q;
      default:   lvl_act  = 1'b0;
    endcase
  end

  // next state
  always_comb begin
    en_ld = hit & (do_en | do_dis);
    en_d  = hit & do_en;

    lat_d = lat_q;
    if (ack || (hit && do_clr)) lat_d = 1'b0;
    if (edge_act || (hit && do_set)) lat_d = 1'b1;

    mode_ld = hit & wr_mode;
    mode_d  = mode_t'{trig: trig_e'(wdata[6:5]), prio: wdata[PRIO_W-1:0]};
    vec_ld  = hit & wr_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      lat_q  <= 1'b0;
      prev_q <= 1'b0;
      mode_q <= '0;
      vec_q  <= '0;
    end else begin
      prev_q <= src_in;
      lat_q  <= lat_d;
      if (en_ld)   en_q   <= en_d;
      if (mode_ld) mode_q <= mode_d;
      if (vec_ld)  vec_q  <= wdata;
    end
  end

  assign pend = lat_q | lvl_act;
  assign en   = en_q;
  assign mode = mode_q;
  assign vec  = vec_q;

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_nest_pkg::*;
#(
  parameter int NUM_SRC = 128
)(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [MAX_SRC-1:0]             cand,
  input  logic [MAX_SRC-1:0][PRIO_W-1:0] prio_all,
  output logic                           c_valid,
  output logic [PRIO_W-1:0]              c_prio,
  output logic                           q_valid,
  output logic [SEL_W-1:0]               q_idx,
  output logic [PRIO_W-1:0]              q_prio
);

  logic [SEL_W-1:0] c_idx;

  // strict compare in ascending order keeps the lowest index on ties
  always_comb begin
    c_valid = 1'b0;
    c_idx   = '0;
    c_prio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (cand[i] && (!c_valid || (prio_all[i] > c_prio))) begin
        c_valid = 1'b1;
        c_idx   = SEL_W'(i);
        c_prio  = prio_all[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_idx   <= '0;
      q_prio  <= '0;
    end else begin
      q_valid <= c_valid;
      q_idx   <= c_idx;
      q_prio  <= c_prio;
    end
  end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
  import irq_nest_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  level_t           push_val,
  output level_t           top,
  output logic [CNT_W-1:0] depth,
  output logic             empty,
  output logic             full
);

  level_t           stk_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;
  logic [PTR_W-1:0] wr_ptr, top_ptr;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CNT_W'(DEPTH));
    do_push = push & ~full;
    do_pop  = pop & ~empty & ~do_push;
    cnt_d   = cnt_q;
    if (do_push)     cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop) cnt_d = cnt_q - CNT_W'(1);
    wr_ptr  = PTR_W'(cnt_q);
    top_ptr = PTR_W'(cnt_q - CNT_W'(1));
    top     = empty ? '0 : stk_q[top_ptr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (do_push) stk_q[wr_ptr] <= push_val;
    end
  end

  assign depth = cnt_q;

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
  import irq_nest_pkg::*;
#(
  parameter  int NUM_SRC = 128,
  parameter  int DEPTH   = 8,
  localparam int CNT_W   = $clog2(DEPTH + 1)
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [7:0]         bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               irq_n
);

  logic [SEL_W-1:0]              sel_q;
  logic [DATA_W-1:0]             spu_q;
  logic                          irq_n_q, req_d;
  logic                          sel_live;
  logic                          wr_sel, wr_spu, wr_mode, wr_vec;
  logic                          do_en, do_dis, do_clr, do_set, do_eoi;
  logic [MAX_SRC-1:0]            src_pad;
  logic [MAX_SRC-1:0]            pend_all, en_all, ack_vec;
  mode_t [MAX_SRC-1:0]           mode_all;
  logic [MAX_SRC-1:0][PRIO_W-1:0] prio_all;
  logic [MAX_SRC-1:0][DATA_W-1:0] vec_all;
  logic                          c_valid, q_valid;
  logic [PRIO_W-1:0]             c_prio, q_prio;
  logic [SEL_W-1:0]              q_idx;
  level_t                        top, push_val;
  logic [CNT_W-1:0]              stk_depth;
  logic                          stk_empty, stk_full;
  logic                          ivr_hit, rd_take;

  // bus decode
  always_comb begin
    wr_sel  = bus_wr && (bus_addr == A_SEL);
    wr_spu  = bus_wr && (bus_addr == A_SPU);
    wr_mode = bus_wr && (bus_addr == A_MODE);
    wr_vec  = bus_wr && (bus_addr == A_VEC);
    do_en   = bus_wr && (bus_addr == A_EN);
    do_dis  = bus_wr && (bus_addr == A_DIS);
    do_clr  = bus_wr && (bus_addr == A_CLR);
    do_set  = bus_wr && (bus_addr == A_SET);
    do_eoi  = bus_wr && (bus_addr == A_EOI);
    sel_live = (32'(sel_q) < NUM_SRC);
  end

  always_comb begin
    src_pad = '0;
    src_pad[NUM_SRC-1:0] = src_in;
  end

  // per-source state
  for (genvar g = 0; g < MAX_SRC; g++) begin : g_src
    if (g < NUM_SRC) begin : g_live
      irq_src_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_in  (src_pad[g]),
        .hit     (sel_live && (sel_q == SEL_W'(g))),
        .wr_mode (wr_mode),
        .wr_vec  (wr_vec),
        .do_en   (do_en),
        .do_dis  (do_dis),
        .do_clr  (do_clr),
        .do_set  (do_set),
        .ack     (ack_vec[g]),
        .wdata   (bus_wdata),
        .pend    (pend_all[g]),
        .en      (en_all[g]),
        .mode    (mode_all[g]),
        .vec     (vec_all[g])
      );
    end else begin : g_tie
      assign pend_all[g] = 1'b0;
      assign en_all[g]   = 1'b0;
      assign mode_all[g] = '0;
      assign vec_all[g]  = '0;
    end
  end

  always_comb begin
    for (int i = 0; i < MAX_SRC; i++) prio_all[i] = mode_all[i].prio;
  end

  irq_prio_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand     (pend_all & en_all),
    .prio_all (prio_all),
    .c_valid  (c_valid),
    .c_prio   (c_prio),
    .q_valid  (q_valid),
    .q_idx    (q_idx),
    .q_prio   (q_prio)
  );

  // acknowledge path: registered winner against the live stack
  always_comb begin
    ivr_hit  = q_valid && !stk_full && (stk_empty || (q_prio > top.prio));
    rd_take  = bus_rd && (bus_addr == A_IVR) && ivr_hit;
    push_val = level_t'{prio: q_prio, idx: q_idx};
    ack_vec  = '0;
    if (rd_take) ack_vec[q_idx] = 1'b1;
    req_d    = c_valid && !stk_full && (stk_empty || (c_prio > top.prio));
  end

  irq_level_stack #(.DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rd_take),
    .pop      (do_eoi),
    .push_val (push_val),
    .top      (top),
    .depth    (stk_depth),
    .empty    (stk_empty),
    .full     (stk_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      spu_q   <= '0;
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= ~req_d;
      if (wr_sel) sel_q <= bus_wdata[SEL_W-1:0];
      if (wr_spu) spu_q <= bus_wdata;
    end
  end

  // read mux
  always_comb begin
    case (bus_addr)
      A_SEL:   bus_rdata = {25'b0, sel_q};
      A_MODE:  bus_rdata = mode_word(mode_all[sel_q]);
      A_VEC:   bus_rdata = vec_all[sel_q];
      A_IVR:   bus_rdata = ivr_hit ? vec_all[q_idx] : spu_q;
      A_STAT:  bus_rdata = stk_empty ? '0 : {25'b0, top.idx};
      A_PEND0: bus_rdata = pend_all[31:0];
      A_PEND1: bus_rdata = pend_all[63:32];
      A_PEND2: bus_rdata = pend_all[95:64];
      A_PEND3: bus_rdata = pend_all[127:96];
      A_MASK:  bus_rdata = {31'b0, en_all[sel_q]};
      A_SPU:   bus_rdata = spu_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_n = irq_n_q;

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
  import irq_nest_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
)(
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [7:0]       bus_addr,
  input logic             irq_n,
  input logic [CNT_W-1:0] depth,
  input logic             en_sel,
  input logic             sel_live,
  input logic             any_cand
);

  p_en_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_EN) && sel_live) |=> en_sel);

  p_dis_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_DIS)) |=> !en_sel);

  p_irq_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(any_cand));

  p_push_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (depth > $past(depth)) |-> $past(bus_rd && (bus_addr == A_IVR)));

  p_eoi_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == A_EOI) && (depth != '0)) |=> (depth == $past(depth) - CNT_W'(1)));

  p_depth_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= CNT_W'(DEPTH));

endmodule

bind irq_nest_ctrl irq_nest_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .irq_n    (irq_n),
  .depth    (stk_depth),
  .en_sel   (en_all[sel_q]),
  .sel_live (sel_live),
  .any_cand (|(pend_all & en_all))
);

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;

  localparam int NSRC = 80;
  localparam logic [7:0] SEL = 8'h00, MODE = 8'h04, VEC = 8'h08, IVR = 8'h10,
                         STAT = 8'h18, PND0 = 8'h20, PND2 = 8'h28, PND3 = 8'h2C,
                         MSK = 8'h30, EOI = 8'h38, SPU = 8'h3C, ENA = 8'h40,
                         DSA = 8'h44, CLRP = 8'h48, SETP = 8'h4C;

  logic            clk, rst_n, bus_wr, bus_rd, irq_n;
  logic [7:0]      bus_addr;
  logic [31:0]     bus_wdata, bus_rdata;
  logic [NSRC-1:0] src_in;

  int nchk, nfail;
  bit done;

  int          prio_m [NSRC];
  logic [31:0] vec_m  [NSRC];
  bit          cand_m [NSRC];

  irq_nest_ctrl #(.NUM_SRC(NSRC), .DEPTH(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rchk(string req, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    brd(a, d);
    check(req, d, exp);
  endtask

  task automatic prog(int s, int p, logic [31:0] v);
    bwr(SEL, s);
    bwr(MODE, 32'h40 | p);
    bwr(VEC, v);
    bwr(ENA, 0);
  endtask

  function automatic int best_src();
    int b;
    b = -1;
    for (int i = 0; i < NSRC; i++)
      if (cand_m[i] && (b < 0 || prio_m[i] > prio_m[b])) b = i;
    return b;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int w, sd;
    nchk = 0; nfail = 0; done = 0;
    sd = $urandom(2024);
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0; src_in = '0;
    for (int i = 0; i < NSRC; i++) begin prio_m[i] = 0; vec_m[i] = 0; cand_m[i] = 0; end
    #3 check("R10 irq_n in reset", {31'b0, irq_n}, 32'h1);
    tick(2);
    rst_n = 1'b1;
    tick(1);

    // R10 reset state
    rchk("R10 status", STAT, 0);
    rchk("R10 mode", MODE, 0);
    rchk("R10 vector", VEC, 0);
    rchk("R10 mask", MSK, 0);
    rchk("R10 spurious ivr", IVR, 0);
    rchk("R10 pending", PND0, 0);

    // R1 select / mode / vector
    bwr(SEL, 32'hFFFF_FF85);
    rchk("R1 select bits", SEL, 32'h05);
    bwr(MODE, 32'h65);
    rchk("R1 mode", MODE, 32'h65);
    bwr(MODE, 32'hFFFF_FFFF);
    rchk("R1 mode reserved bits", MODE, 32'h67);
    bwr(VEC, 32'hA5A5_1234);
    rchk("R1 vector", VEC, 32'hA5A5_1234);
    bwr(MODE, 0);

    // R11 out-of-range select
    bwr(SEL, 100);
    bwr(VEC, 32'h1111_2222);
    bwr(MODE, 32'h47);
    bwr(ENA, 0);
    bwr(SETP, 0);
    rchk("R11 vector ignored", VEC, 0);
    rchk("R11 mode ignored", MODE, 0);
    rchk("R11 enable ignored", MSK, 0);
    rchk("R11 no pending", PND3, 0);
    tick(2);
    check("R11 no request", {31'b0, irq_n}, 32'h1);

    // R2 enable / disable
    bwr(SEL, 3);
    bwr(ENA, 0);
    rchk("R2 enable readback", MSK, 1);
    bwr(DSA, 0);
    rchk("R2 disable readback", MSK, 0);
    bwr(SETP, 0);
    tick(2);
    check("R2 disabled pending no irq", {31'b0, irq_n}, 32'h1);
    bwr(ENA, 0);
    tick(2);
    check("R2 enabled pending irq", {31'b0, irq_n}, 32'h0);
    bwr(DSA, 0);
    tick(2);
    check("R2 disabled again", {31'b0, irq_n}, 32'h1);
    bwr(CLRP, 0);

    // R5 R7 R8 random rounds
    for (int r = 0; r < 30; r++) begin
      int s [4];
      for (int k = 0; k < 4; k++) begin
        s[k] = $urandom % NSRC;
        prio_m[s[k]] = $urandom % 8;
        vec_m[s[k]] = $urandom;
        cand_m[s[k]] = 1;
        prog(s[k], prio_m[s[k]], vec_m[s[k]]);
        bwr(SETP, 0);
      end
      w = best_src();
      tick(2);
      check("R5 random irq", {31'b0, irq_n}, 32'h0);
      rchk("R5 random winner vector", IVR, vec_m[w]);
      rchk("R8 random status", STAT, w);
      tick(2);
      check("R7 no equal or lower re-request", {31'b0, irq_n}, 32'h1);
      for (int k = 0; k < 4; k++) begin
        bwr(SEL, s[k]);
        bwr(CLRP, 0);
        bwr(DSA, 0);
        cand_m[s[k]] = 0;
      end
      bwr(EOI, 0);
      rchk("R9 random pop", STAT, 0);
    end

    // R4 trigger types
    bwr(SEL, 10); bwr(MODE, 32'h00);
    src_in[10] = 1'b1; tick(1);
    rchk("R4 level-high active", PND0, 32'h400);
    src_in[10] = 1'b0; tick(1);
    rchk("R4 level-high idle", PND0, 0);
    bwr(SEL, 11); bwr(MODE, 32'h20);
    rchk("R4 level-low active", PND0, 32'h800);
    src_in[11] = 1'b1; tick(1);
    rchk("R4 level-low idle", PND0, 0);
    bwr(MODE, 32'h00); src_in[11] = 1'b0;
    bwr(SEL, 12); bwr(MODE, 32'h40);
    src_in[12] = 1'b1; tick(1); src_in[12] = 1'b0; tick(1);
    rchk("R4 rising latched", PND0, 32'h1000);
    bwr(CLRP, 0);
    rchk("R3 clear latched edge", PND0, 0);
    bwr(SEL, 13); bwr(MODE, 32'h60);
    src_in[13] = 1'b1; tick(2);
    rchk("R4 falling ignores rise", PND0, 0);
    src_in[13] = 1'b0; tick(1);
    rchk("R4 falling latched", PND0, 32'h2000);
    bwr(CLRP, 0);

    // R3 software set / clear and word placement
    bwr(SEL, 14); bwr(SETP, 0);
    rchk("R3 set word0", PND0, 32'h4000);
    bwr(CLRP, 0);
    rchk("R3 clear word0", PND0, 0);
    bwr(SEL, 70); bwr(SETP, 0);
    rchk("R3 set word2", PND2, 32'h40);
    bwr(CLRP, 0);
    rchk("R3 clear word2", PND2, 0);

    // R6 spurious
    bwr(SPU, 32'hDEAD_BEEF);
    rchk("R6 spurious vector", IVR, 32'hDEAD_BEEF);
    rchk("R6 no push", STAT, 0);

    // R5 R7 R9 nesting
    prog(20, 1, 32'h100);
    prog(21, 4, 32'h101);
    prog(22, 4, 32'h102);
    prog(30, 6, 32'h103);
    bwr(SEL, 20); bwr(SETP, 0); tick(2);
    check("R5 first irq", {31'b0, irq_n}, 0);
    rchk("R5 first vector", IVR, 32'h100);
    rchk("R8 first status", STAT, 20);
    bwr(SEL, 22); bwr(SETP, 0);
    bwr(SEL, 21); bwr(SETP, 0); tick(2);
    check("R7 higher nests", {31'b0, irq_n}, 0);
    rchk("R5 tie lowest index", IVR, 32'h101);
    rchk("R8 nested status", STAT, 21);
    tick(2);
    check("R7 equal priority blocked", {31'b0, irq_n}, 1);
    bwr(EOI, 0); tick(2);
    rchk("R9 pop to lower level", STAT, 20);
    check("R7 equal released after pop", {31'b0, irq_n}, 0);
    rchk("R5 second of tie", IVR, 32'h102);
    bwr(SEL, 30); bwr(SETP, 0); tick(2);
    rchk("R5 top level vector", IVR, 32'h103);
    rchk("R8 top status", STAT, 30);
    bwr(SEL, 20); bwr(SETP, 0); tick(2);
    check("R7 lower priority blocked", {31'b0, irq_n}, 1);
    for (int k = 0; k < 8; k++) bwr(EOI, 0);
    rchk("R9 eight pops idle", STAT, 0);
    tick(2);
    check("R9 pending after idle", {31'b0, irq_n}, 0);
    rchk("R9 vector after idle", IVR, 32'h100);
    bwr(EOI, 0); tick(2);
    check("R6 nothing left", {31'b0, irq_n}, 1);
    rchk("R6 spurious after drain", IVR, 32'hDEAD_BEEF);

    // R9 full depth
    for (int k = 0; k < 8; k++) begin
      prog(40 + k, k, 32'h200 + k);
      bwr(SETP, 0); tick(2);
      rchk("R9 fill level", IVR, 32'h200 + k);
    end
    rchk("R9 full status", STAT, 47);
    tick(2);
    check("R9 full no irq", {31'b0, irq_n}, 1);
    for (int k = 0; k < 8; k++) bwr(EOI, 0);
    rchk("R9 drained status", STAT, 0);
    bwr(EOI, 0);
    rchk("R9 pop on empty", STAT, 0);
    tick(2);
    check("R9 drained irq", {31'b0, irq_n}, 1);
    rchk("R6 drained ivr", IVR, 32'hDEAD_BEEF);

    done = 1;
    report();
    $finish;
  end

endmodule